// File: doc/BRIEF.md
# Soft-Start Reference Sequencer

This block produces the stepped start-up ramp for the references of two regulation loops. After power-on it waits until two digitised supply-good flags are both high. The flags may rise in either order. It then advances a shared step code from zero to full scale. A divide-by-64 prescaler paces the steps, so each step lasts 64 oscillator periods and the whole 64-step climb takes 4096 periods.

Each channel has its own static 12-bit final value. Its reference output is the step code times that value, shifted right by six. Both references therefore rise in equal sixty-fourth increments and land exactly on their final values when the code reaches 64. At that point a done flag goes high and stays high.

Losing either supply-good flag sends the sequencer straight back to its idle state. There the code, the prescaler and the done flag are cleared, and a later start runs the full ramp again from zero.

The sequencer has three states. `SS_IDLE` holds the code at zero. `SS_RAMP` advances the code once per prescaler tick. `SS_DONE` holds the code at 64. The transitions are:

| Transition | Condition |
|---|---|
| IDLE to RAMP | both supply-good flags are high |
| RAMP to DONE | a tick arrives while the code is 63 |
| RAMP to IDLE | either flag is low |
| DONE to IDLE | either flag is low |

Top module: `softstart_seq`

## Requirements
- R1: While `rst_n` is low, `step_code`, `ref_a`, `ref_b` and `ramp_done` are all 0.
- R2: `step_code` stays 0 in any cycle where `sup_a_ok` and `sup_b_ok` have not both been high since the last idle entry, whichever flag rises first.
- R3: If both flags are first sampled high at clock edge k, `step_code` becomes 1 at edge k+64 and rises by exactly 1 every 64 edges after that.
- R4: `step_code` is 7 bits wide, reaches 64 at edge k+4096 and never exceeds 64.
- R5: `ref_a` = (`step_code` × `final_a`) >> 6 and `ref_b` = (`step_code` × `final_b`) >> 6 in every cycle. At code 64 each reference equals its final value exactly.
- R6: `ramp_done` rises in the same cycle that `step_code` reaches 64. It stays high while both flags stay high, and it is never high with any other code.
- R7: While both flags stay high, neither reference ever decreases from one cycle to the next.
- R8: If either flag is sampled low, then after that edge `step_code` is 0 and `ramp_done` is 0. The next ramp again takes 64 edges to its first step and 4096 edges in total.
- R9: While the sequencer is idle, both references are 0 whatever the final values are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sup_a_ok | input | 1 | First supply-good flag |
| sup_b_ok | input | 1 | Second supply-good flag |
| final_a | input | 12 | Final reference value, channel A |
| final_b | input | 12 | Final reference value, channel B |
| step_code | output | 7 | Shared ramp step code, 0 to 64 |
| ref_a | output | 12 | Scaled reference, channel A |
| ref_b | output | 12 | Scaled reference, channel B |
| ramp_done | output | 1 | High once the ramp has reached full scale |

## Verification
The hardest case to reach from the ports is a supply-good dropout in the middle of a ramp. The prescaler must restart cleanly from zero, so the next first step arrives after 64 cycles rather than at a leftover phase. The stimulus runs a ramp for about a thousand cycles, pulls one flag low for a single cycle, then lets the ramp restart. The bench measures the gap to the first step and the total length of the second ramp. Separate passes raise the flags in both orders and use extreme final values (1 and 4032) to exercise the scaling arithmetic.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [1:0] {
        SS_IDLE = 2'd0,
        SS_RAMP = 2'd1,
        SS_DONE = 2'd2
    } ss_state_t;

endpackage

// File: rtl/ss_prescaler.sv
module ss_prescaler #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int DIV = 1 << DIV_LOG2;
    localparam logic [DIV_LOG2-1:0] LAST = DIV_LOG2'(DIV - 1);

    logic [DIV_LOG2-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        tick = !clr && (cnt_q == LAST);
    end

endmodule

// File: rtl/ss_seq_fsm.sv
module ss_seq_fsm
    import ss_pkg::*;
#(
    parameter int STEP_LOG2 = 6,
    parameter int CODE_W    = STEP_LOG2 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              good_a,
    input  logic              good_b,
    input  logic              tick,
    output logic              run_en,
    output logic              done,
    output logic [CODE_W-1:0] code
);
    localparam int NUM_STEPS = 1 << STEP_LOG2;
    localparam logic [CODE_W-1:0] CODE_PENULT = CODE_W'(NUM_STEPS - 1);

    ss_state_t         state_q, state_d;
    logic [CODE_W-1:0] code_q;
    logic              both_good;

    assign both_good = good_a && good_b;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SS_IDLE: begin
                if (both_good) state_d = SS_RAMP;
            end
            SS_RAMP: begin
                if (!both_good) begin
                    state_d = SS_IDLE;
                end else if (tick && (code_q == CODE_PENULT)) begin
                    state_d = SS_DONE;
                end
            end
            SS_DONE: begin
                if (!both_good) state_d = SS_IDLE;
            end
            default: state_d = SS_IDLE;
        endcase
    end

    // step code register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
        end else if (!both_good) begin
            code_q <= '0;
        end else if ((state_q == SS_RAMP) && tick) begin
            code_q <= code_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        run_en = (state_q == SS_RAMP) && both_good;
        done   = (state_q == SS_DONE);
        code   = code_q;
    end

endmodule

// File: rtl/ss_ref_scale.sv
module ss_ref_scale #(
    parameter int CODE_W = 7,
    parameter int REF_W  = 12,
    parameter int SHIFT  = 6
) (
    input  logic [CODE_W-1:0] code,
    input  logic [REF_W-1:0]  final_val,
    output logic [REF_W-1:0]  ref_val
);
    localparam int PROD_W = CODE_W + REF_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod    = PROD_W'(code) * PROD_W'(final_val);
        ref_val = prod[SHIFT +: REF_W];
    end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq #(
    parameter int DIV_LOG2  = 6,
    parameter int STEP_LOG2 = 6,
    parameter int REF_W     = 12,
    parameter int CODE_W    = STEP_LOG2 + 1
) (
    input  logic              clk_osc,
    input  logic              rst_n,
    input  logic              sup_a_ok,
    input  logic              sup_b_ok,
    input  logic [REF_W-1:0]  final_a,
    input  logic [REF_W-1:0]  final_b,
    output logic [CODE_W-1:0] step_code,
    output logic [REF_W-1:0]  ref_a,
    output logic [REF_W-1:0]  ref_b,
    output logic              ramp_done
);
    localparam int NUM_CH = 2;

    logic                         tick;
    logic                         run_en;
    logic [NUM_CH-1:0][REF_W-1:0] fin_vec;
    logic [NUM_CH-1:0][REF_W-1:0] ref_vec;

    ss_prescaler #(.DIV_LOG2(DIV_LOG2)) u_presc (
        .clk   (clk_osc),
        .rst_n (rst_n),
        .clr   (!run_en),
        .tick  (tick)
    );

    ss_seq_fsm #(.STEP_LOG2(STEP_LOG2), .CODE_W(CODE_W)) u_fsm (
        .clk    (clk_osc),
        .rst_n  (rst_n),
        .good_a (sup_a_ok),
        .good_b (sup_b_ok),
        .tick   (tick),
        .run_en (run_en),
        .done   (ramp_done),
        .code   (step_code)
    );

    assign fin_vec[0] = final_a;
    assign fin_vec[1] = final_b;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        ss_ref_scale #(.CODE_W(CODE_W), .REF_W(REF_W), .SHIFT(STEP_LOG2)) u_scale (
            .code      (step_code),
            .final_val (fin_vec[ch]),
            .ref_val   (ref_vec[ch])
        );
    end

    assign ref_a = ref_vec[0];
    assign ref_b = ref_vec[1];

endmodule

// File: rtl/ss_checker.sv
module ss_checker #(
    parameter int STEP_LOG2 = 6,
    parameter int REF_W     = 12,
    parameter int CODE_W    = STEP_LOG2 + 1
) (
    input logic              clk_osc,
    input logic              rst_n,
    input logic              sup_a_ok,
    input logic              sup_b_ok,
    input logic [REF_W-1:0]  final_a,
    input logic [REF_W-1:0]  final_b,
    input logic [CODE_W-1:0] step_code,
    input logic [REF_W-1:0]  ref_a,
    input logic [REF_W-1:0]  ref_b,
    input logic              ramp_done
);
    localparam logic [CODE_W-1:0] FULL = CODE_W'(1 << STEP_LOG2);

    AST_RESET_CLEAR: assert property (@(posedge clk_osc) !rst_n |-> (step_code == '0 && !ramp_done)); // R1
    AST_STEP_BY_ONE: assert property (@(posedge clk_osc) disable iff (!rst_n) (sup_a_ok && sup_b_ok) |=> (step_code == $past(step_code) || step_code == $past(step_code) + 1'b1)); // R3
    AST_CODE_CAP: assert property (@(posedge clk_osc) disable iff (!rst_n) step_code <= FULL); // R4
    AST_FULL_REFS: assert property (@(posedge clk_osc) disable iff (!rst_n) (step_code == FULL) |-> (ref_a == final_a && ref_b == final_b)); // R5
    AST_DONE_AT_FULL: assert property (@(posedge clk_osc) disable iff (!rst_n) ramp_done |-> (step_code == FULL)); // R6
    AST_DONE_HOLD: assert property (@(posedge clk_osc) disable iff (!rst_n) (ramp_done && sup_a_ok && sup_b_ok) |=> ramp_done); // R6
    AST_NO_DECREASE: assert property (@(posedge clk_osc) disable iff (!rst_n) (sup_a_ok && sup_b_ok) |=> (ref_a >= $past(ref_a) && ref_b >= $past(ref_b))); // R7
    AST_DROP_IDLE: assert property (@(posedge clk_osc) disable iff (!rst_n) !(sup_a_ok && sup_b_ok) |=> (step_code == '0 && !ramp_done)); // R8
    AST_IDLE_REFS: assert property (@(posedge clk_osc) disable iff (!rst_n) (step_code == '0) |-> (ref_a == '0 && ref_b == '0)); // R9

endmodule

bind softstart_seq ss_checker #(.STEP_LOG2(STEP_LOG2), .REF_W(REF_W), .CODE_W(CODE_W)) u_chk (
    .clk_osc   (clk_osc),
    .rst_n     (rst_n),
    .sup_a_ok  (sup_a_ok),
    .sup_b_ok  (sup_b_ok),
    .final_a   (final_a),
    .final_b   (final_b),
    .step_code (step_code),
    .ref_a     (ref_a),
    .ref_b     (ref_b),
    .ramp_done (ramp_done)
);

// File: tb/sim_softstart_seq.sv
module sim_softstart_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_a_ok = 1'b0;
    logic        sup_b_ok = 1'b0;
    logic [11:0] final_a = 12'd4095;
    logic [11:0] final_b = 12'd2000;
    logic [6:0]  step_code;
    logic [11:0] ref_a;
    logic [11:0] ref_b;
    logic        ramp_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // behavioural model: cycles since both flags were seen high (-1 = idle)
    int run_cnt = -1;
    int cyc = 0;
    int start_cyc = 0;
    int last_chg = 0;
    int prev_code = 0;
    int prev_ra = 0;
    int prev_rb = 0;
    int prev_run = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    softstart_seq u0 (
        .clk_osc   (clk),
        .rst_n     (rst_n),
        .sup_a_ok  (sup_a_ok),
        .sup_b_ok  (sup_b_ok),
        .final_a   (final_a),
        .final_b   (final_b),
        .step_code (step_code),
        .ref_a     (ref_a),
        .ref_b     (ref_b),
        .ramp_done (ramp_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int exp_code();
        int c;
        if (run_cnt < 0) return 0;
        c = run_cnt / 64;
        return (c > 64) ? 64 : c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= -1;
        end else begin
            cyc <= cyc + 1;
            if (!(sup_a_ok && sup_b_ok)) begin
                run_cnt <= -1;
            end else if (run_cnt < 0) begin
                run_cnt   <= 0;
                start_cyc <= cyc + 1;
            end else if (run_cnt < 4096) begin
                run_cnt <= run_cnt + 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            int ec;
            ec = exp_code();
            check(run_cnt < 0 ? "R2 idle code" : "R3 step code", int'(step_code), ec);
            check("R5 ref_a", int'(ref_a), (ec * int'(final_a)) / 64);
            check("R5 ref_b", int'(ref_b), (ec * int'(final_b)) / 64);
            check("R6 done", int'(ramp_done), (ec == 64) ? 1 : 0);
            if (run_cnt > 0 && prev_run >= 0) begin
                check("R7 ref_a non-decreasing", int'(ref_a >= 12'(prev_ra)), 1);
                check("R7 ref_b non-decreasing", int'(ref_b >= 12'(prev_rb)), 1);
            end
            if (int'(step_code) != prev_code && step_code != 7'd0) begin
                if (step_code == 7'd1) check("R3 first step gap", cyc - start_cyc, 64);
                else                   check("R3 step spacing", cyc - last_chg, 64);
                if (step_code == 7'd64) check("R4 ramp length", cyc - start_cyc, 4096);
                last_chg = cyc;
            end
            prev_code = int'(step_code);
            prev_ra   = int'(ref_a);
            prev_rb   = int'(ref_b);
            prev_run  = run_cnt;
        end
    end

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 5000 && !ramp_done; i++) @(negedge clk);
        check("R6 done reached", int'(ramp_done), 1);
        check("R5 ref_a at full", int'(ref_a), int'(final_a));
        check("R5 ref_b at full", int'(ref_b), int'(final_b));
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cycles(3);
        check("R1 reset code", int'(step_code), 0);
        check("R1 reset refs", int'(ref_a | ref_b), 0);
        check("R1 reset done", int'(ramp_done), 0);
        rst_n = 1'b1;

        // only one flag high: nothing may move
        wait_cycles(5);
        sup_a_ok = 1'b1;
        wait_cycles(200);
        check("R2 one flag only", int'(step_code), 0);
        check("R9 idle refs zero", int'(ref_a | ref_b), 0);

        sup_b_ok = 1'b1;
        wait_done();
        wait_cycles(100);
        check("R4 saturated", int'(step_code), 64);
        check("R6 done held", int'(ramp_done), 1);

        // dropout from the done state
        sup_a_ok = 1'b0;
        wait_cycles(1);
        check("R8 code cleared", int'(step_code), 0);
        check("R8 done cleared", int'(ramp_done), 0);

        // reverse order: b then a
        sup_b_ok = 1'b0;
        wait_cycles(20);
        sup_b_ok = 1'b1;
        wait_cycles(50);
        check("R2 b only", int'(step_code), 0);
        sup_a_ok = 1'b1;
        wait_cycles(1000);
        check("R3 mid ramp code", int'(step_code), 15);

        // single-cycle dropout mid-ramp
        sup_b_ok = 1'b0;
        wait_cycles(1);
        check("R8 mid-ramp clear", int'(step_code), 0);
        sup_b_ok = 1'b1;
        wait_cycles(30);
        check("R8 restart from zero", int'(step_code), 0);
        wait_done();

        // new final values while idle
        sup_a_ok = 1'b0;
        sup_b_ok = 1'b0;
        wait_cycles(2);
        final_a = 12'd1;
        final_b = 12'd4032;
        wait_cycles(5);
        check("R9 idle refs new finals", int'(ref_a | ref_b), 0);
        sup_a_ok = 1'b1;
        sup_b_ok = 1'b1;
        wait_cycles(64 * 32 + 1);
        check("R5 half ramp ref_b", int'(ref_b), 2016);
        check("R5 half ramp ref_a", int'(ref_a), 0);
        wait_done();
        wait_cycles(10);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule